// File: doc/BRIEF.md
# NOR Flash Page-Burst Writer

This block is an SPI master that writes a run of bytes of any length, starting at any 24-bit address, into a serial NOR flash. A client presents the start address and the byte count with a one-cycle `start` pulse. It then supplies the bytes on a valid/ready stream. The block cuts the run into program bursts so that no burst crosses a 256-byte page. It also makes sure the device is ready before each burst.

Each burst follows a fixed sequence. The block reads status until the busy flag clears, with an optional idle delay between reads. It then sends a write-enable frame and finally a program frame that carries the address and the burst's data. Every one of these is its own chip-select frame. The walk is driven by one state machine with these states: IDLE, POLL_CMD, POLL_RD, GAP, WREN, PROG_CMD, PROG_ADDR, PROG_DATA, DONE and ERR. Its transitions are:

- IDLE→DONE when the length is zero, and IDLE→POLL_CMD otherwise.
- POLL_CMD→POLL_RD.
- POLL_RD→GAP after every status read, or POLL_RD→ERR when the poll limit is reached.
- GAP→(POLL_CMD | WREN | PROG_CMD | DONE), following the stored target.
- WREN→GAP.
- PROG_CMD→PROG_ADDR.
- PROG_ADDR→PROG_DATA after the third address byte.
- PROG_DATA→GAP after the last byte of the burst.
- DONE→IDLE and ERR→IDLE.

A status read that shows busy, when the limit is not reached, leads to GAP with POLL_CMD as the target. A status read that shows ready leads to GAP with WREN as the target. After WREN the GAP target is PROG_CMD. After the last byte of a burst the GAP target is POLL_CMD for the next burst, or DONE after the final burst.

Top module: `nor_page_writer`

## Requirements
- R1: A program frame is a single chip-select assertion that carries opcode 0x02, then the 24-bit burst address with the most significant byte first, then the burst's data bytes.
- R2: The first burst holds min(256 − (address mod 256), length) bytes. Every later burst starts on a 256-byte page boundary and holds min(256, remaining) bytes.
- R3: Before each burst the block sends a status frame: opcode 0x05 out, then one byte in. It repeats this frame while bit 0 of the returned byte is 1. The other status bits have no effect.
- R4: Each program frame is preceded by a one-byte write-enable frame (0x06). That frame is itself preceded by a status frame that returned bit 0 = 0.
- R5: Between two consecutive status frames, the chip select stays high for 4·CLK_DIV + `poll_gap` clock cycles. With `poll_gap` = 0 the gap is the minimum frame gap.
- R6: The address advances by each burst length and the remaining count falls by the same amount. `done` pulses for one cycle once the count reaches zero, and the stream bytes land at consecutive addresses in stream order.
- R7: The SPI runs in mode 0 with MSB first. SCLK idles low and is low at every chip-select edge, and MOSI changes only while SCLK is low. Between frames the chip select stays high for at least two SCLK periods (4·CLK_DIV cycles).
- R8: A start with length 0 raises `done` in the next cycle and makes no SPI frame.
- R9: When POLL_LIMIT consecutive status reads of one burst all return busy, the block pulses `error`, leaves the chip select high, sends no program frame and returns to idle.
- R10: A stream byte is taken on a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is high only inside a program frame's data phase, and gaps in `wr_valid` only stretch the frame.
- R11: After reset `spi_cs_n` is 1, `spi_sclk` is 0, and `busy`, `done`, `error` and `wr_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request, accepted when idle |
| start_addr | input | 24 | Flash address of the first byte |
| xfer_len | input | LEN_W | Number of bytes to write |
| poll_gap | input | DELAY_W | Extra clock cycles between busy status reads |
| wr_data | input | 8 | Stream data byte |
| wr_valid | input | 1 | Stream byte present |
| wr_ready | output | 1 | Stream byte taken this cycle if valid |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when the run completes |
| error | output | 1 | One-cycle pulse when the poll limit is hit |

## Verification
The hardest condition to reach from the ports is a status read that keeps returning busy across many frames. The bench covers it with a behavioural flash on the SPI pins. That model reports busy for a set number of polls after each program frame, or indefinitely in a stuck mode, and it sets every status bit except bit 0 to 1 so that only the busy flag matters. One run starts unaligned so that three bursts of different sizes occur, each preceded by several busy polls. On that run the bench measures the chip-select gap between busy polls. A second run keeps the model stuck until the poll limit ends the request.

// File: rtl/npw_pkg.sv
package npw_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_POLL_CMD,
        S_POLL_RD,
        S_GAP,
        S_WREN,
        S_PROG_CMD,
        S_PROG_ADDR,
        S_PROG_DATA,
        S_DONE,
        S_ERR
    } npw_state_t;

    localparam logic [7:0] OP_PROGRAM = 8'h02;
    localparam logic [7:0] OP_STATUS  = 8'h05;
    localparam logic [7:0] OP_WREN    = 8'h06;
    localparam logic [7:0] OP_FILL    = 8'h00;
endpackage

// File: rtl/npw_byte_shifter.sv
// One SPI mode-0 byte: MSB first, MISO sampled on the rising edge,
// MOSI updated on the falling edge. CLK_DIV clk cycles per SCLK half period.
module npw_byte_shifter #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       active,
    output logic       fin,
    output logic [7:0] rx_byte
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

    logic [DIV_W-1:0] div_q;
    logic [2:0]       bit_q;
    logic [7:0]       sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            sclk    <= 1'b0;
            mosi    <= 1'b0;
            active  <= 1'b0;
            fin     <= 1'b0;
            rx_byte <= '0;
        end else begin
            fin <= 1'b0;
            if (go && !active) begin
                active <= 1'b1;
                sh_q   <= tx_byte;
                mosi   <= tx_byte[7];
                sclk   <= 1'b0;
                div_q  <= '0;
                bit_q  <= '0;
            end else if (active) begin
                if (div_q == DIV_LAST) begin
                    div_q <= '0;
                    if (!sclk) begin
                        sclk    <= 1'b1;
                        rx_byte <= {rx_byte[6:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bit_q == 3'd7) begin
                            active <= 1'b0;
                            fin    <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 3'd1;
                            sh_q  <= {sh_q[6:0], 1'b0};
                            mosi  <= sh_q[6];
                        end
                    end
                end else begin
                    div_q <= div_q + DIV_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/npw_burst_planner.sv
// Size of the next program burst: bytes left in the current page, clipped
// to the bytes left in the request.
module npw_burst_planner #(
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 16,
    parameter int PAGE_BYTES = 256
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  remain,
    output logic [LEN_W-1:0]  chunk
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    logic [LEN_W-1:0] room;

    always_comb begin
        room  = LEN_W'(PAGE_BYTES) - LEN_W'(addr[PAGE_W-1:0]);
        chunk = (remain < room) ? remain : room;
    end
endmodule

// File: rtl/nor_page_writer.sv
module nor_page_writer #(
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 16,
    parameter int DELAY_W    = 16,
    parameter int CLK_DIV    = 2,
    parameter int PAGE_BYTES = 256,
    parameter int POLL_LIMIT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic [LEN_W-1:0]   xfer_len,
    input  logic [DELAY_W-1:0] poll_gap,
    input  logic [7:0]         wr_data,
    input  logic               wr_valid,
    output logic               wr_ready,
    output logic               spi_cs_n,
    output logic               spi_sclk,
    output logic               spi_mosi,
    input  logic               spi_miso,
    output logic               busy,
    output logic               done,
    output logic               error
);
    import npw_pkg::*;

    localparam int GAP_CYC = 4 * CLK_DIV;
    localparam int GAP_W   = DELAY_W + 1;
    localparam int POLL_W  = $clog2(POLL_LIMIT + 1);
    localparam int NADDR   = ADDR_W / 8;

    npw_state_t st_q, st_d, gap_tgt_q;

    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  remain_q, chunk_q, left_q, plan_chunk;
    logic [GAP_W-1:0]  gap_q;
    logic [POLL_W-1:0] poll_q;
    logic [1:0]        aidx_q;
    logic              launched_q;

    logic       eng_go, eng_act, eng_fin;
    logic [7:0] eng_tx, eng_rx;
    logic       in_frame, stat_busy, poll_over, last_byte, last_burst;

    npw_burst_planner #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
    ) planner_i (
        .addr(addr_q), .remain(remain_q), .chunk(plan_chunk)
    );

    npw_byte_shifter #(.CLK_DIV(CLK_DIV)) shifter_i (
        .clk(clk), .rst_n(rst_n), .go(eng_go), .tx_byte(eng_tx),
        .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
        .active(eng_act), .fin(eng_fin), .rx_byte(eng_rx)
    );

    assign stat_busy  = eng_rx[0];
    assign poll_over  = (poll_q == POLL_W'(POLL_LIMIT - 1));
    assign last_byte  = (left_q == LEN_W'(1));
    assign last_burst = (remain_q == chunk_q);

    // Byte launch and frame-level outputs
    always_comb begin
        in_frame = (st_q == S_POLL_CMD) || (st_q == S_POLL_RD) ||
                   (st_q == S_WREN) || (st_q == S_PROG_CMD) ||
                   (st_q == S_PROG_ADDR) || (st_q == S_PROG_DATA);
        wr_ready = (st_q == S_PROG_DATA) && !launched_q && !eng_act;
        eng_go   = in_frame && !launched_q && !eng_act &&
                   ((st_q != S_PROG_DATA) || wr_valid);
        unique case (st_q)
            S_POLL_CMD:  eng_tx = OP_STATUS;
            S_WREN:      eng_tx = OP_WREN;
            S_PROG_CMD:  eng_tx = OP_PROGRAM;
            S_PROG_ADDR: eng_tx = addr_q[ADDR_W-1 - 8*aidx_q -: 8];
            S_PROG_DATA: eng_tx = wr_data;
            default:     eng_tx = OP_FILL;
        endcase
        spi_cs_n = !in_frame;
        busy     = (st_q != S_IDLE);
        done     = (st_q == S_DONE);
        error    = (st_q == S_ERR);
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:      if (start) st_d = (xfer_len == '0) ? S_DONE : S_POLL_CMD;
            S_POLL_CMD:  if (eng_fin) st_d = S_POLL_RD;
            S_POLL_RD:   if (eng_fin) st_d = (stat_busy && poll_over) ? S_ERR : S_GAP;
            S_GAP:       if (gap_q == '0) st_d = gap_tgt_q;
            S_WREN:      if (eng_fin) st_d = S_GAP;
            S_PROG_CMD:  if (eng_fin) st_d = S_PROG_ADDR;
            S_PROG_ADDR: if (eng_fin && aidx_q == 2'(NADDR - 1)) st_d = S_PROG_DATA;
            S_PROG_DATA: if (eng_fin && last_byte) st_d = S_GAP;
            S_DONE:      st_d = S_IDLE;
            S_ERR:       st_d = S_IDLE;
            default:     st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_tgt_q  <= S_IDLE;
            addr_q     <= '0;
            remain_q   <= '0;
            chunk_q    <= '0;
            left_q     <= '0;
            gap_q      <= '0;
            poll_q     <= '0;
            aidx_q     <= '0;
            launched_q <= 1'b0;
        end else begin
            if (eng_go)       launched_q <= 1'b1;
            else if (eng_fin) launched_q <= 1'b0;
            unique case (st_q)
                S_IDLE: if (start) begin
                    addr_q   <= start_addr;
                    remain_q <= xfer_len;
                    poll_q   <= '0;
                end
                S_POLL_RD: if (eng_fin) begin
                    if (stat_busy) begin
                        poll_q    <= poll_q + POLL_W'(1);
                        gap_q     <= GAP_W'(GAP_CYC - 1) + GAP_W'(poll_gap);
                        gap_tgt_q <= S_POLL_CMD;
                    end else begin
                        gap_q     <= GAP_W'(GAP_CYC - 1);
                        gap_tgt_q <= S_WREN;
                    end
                end
                S_GAP: if (gap_q != '0) gap_q <= gap_q - GAP_W'(1);
                S_WREN: if (eng_fin) begin
                    gap_q     <= GAP_W'(GAP_CYC - 1);
                    gap_tgt_q <= S_PROG_CMD;
                    chunk_q   <= plan_chunk;
                    left_q    <= plan_chunk;
                    aidx_q    <= '0;
                end
                S_PROG_ADDR: if (eng_fin) aidx_q <= aidx_q + 2'd1;
                S_PROG_DATA: if (eng_fin) begin
                    left_q <= left_q - LEN_W'(1);
                    if (last_byte) begin
                        addr_q    <= addr_q + ADDR_W'(chunk_q);
                        remain_q  <= remain_q - chunk_q;
                        poll_q    <= '0;
                        gap_q     <= GAP_W'(GAP_CYC - 1);
                        gap_tgt_q <= last_burst ? S_DONE : S_POLL_CMD;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/npw_checker.sv
module npw_checker #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [LEN_W-1:0] xfer_len,
    input logic             wr_ready,
    input logic             spi_cs_n,
    input logic             spi_sclk,
    input logic             spi_mosi,
    input logic             busy,
    input logic             done,
    input logic             error
);
    // R7: SCLK is low whenever chip select changes
    a_r7_sclk_low_cs_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> !spi_sclk);
    a_r7_sclk_low_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> !spi_sclk);
    // R7: SCLK only pulses inside a frame
    a_r7_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !spi_cs_n);
    // R7: MOSI holds while SCLK stays high
    a_r7_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));
    // R8: zero length completes in the next cycle
    a_r8_zero_len_done: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && xfer_len == '0) |=> done);
    // R9: error leaves chip select high and never coincides with done
    a_r9_error_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (spi_cs_n && !done));
    // R10: stream accepted only inside a frame
    a_r10_ready_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !spi_cs_n);
    // R11: idle means chip select high
    a_r11_idle_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);
endmodule

bind nor_page_writer npw_checker #(.LEN_W(LEN_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len),
    .wr_ready(wr_ready), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .busy(busy), .done(done), .error(error)
);

// File: tb/nor_page_writer_tb_top.sv
`timescale 1ns/1ps
module nor_page_writer_tb_top;
    localparam int CLK_DIV = 2;
    localparam int POLL_LIMIT = 16;
    localparam int GAP_CYC = 4 * CLK_DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] start_addr = '0;
    logic [15:0] xfer_len = '0;
    logic [15:0] poll_gap = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready, spi_cs_n, spi_sclk, spi_mosi, busy, done, error;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    nor_page_writer #(.CLK_DIV(CLK_DIV), .POLL_LIMIT(POLL_LIMIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .xfer_len(xfer_len), .poll_gap(poll_gap), .wr_data(wr_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .busy(busy), .done(done), .error(error)
    );

    // ---------------- behavioural flash ----------------
    logic [7:0]  mem [int];
    int          bitc, nbytes, seq, polls, busy_polls, wrens, nprog, bad, busy_left, busy_after;
    bit          stuck, cur_busy, last_busy_poll;
    logic [7:0]  sh, op, stat;
    logic [23:0] fa;
    int          prog_addr [0:15];
    int          prog_len  [0:15];
    realtime     t_rise, gap_min_busy, gap_max_busy, gap_min_all;

    task automatic model_clear();
        mem.delete();
        polls = 0; busy_polls = 0; wrens = 0; nprog = 0; bad = 0; seq = 0;
        busy_left = 0; last_busy_poll = 0;
        gap_min_busy = 1.0e9; gap_max_busy = 0.0; gap_min_all = 1.0e9;
    endtask

    always @(negedge spi_cs_n) begin
        if (t_rise > 0.0) begin
            if ($realtime - t_rise < gap_min_all) gap_min_all = $realtime - t_rise;
            if (last_busy_poll) begin
                if ($realtime - t_rise < gap_min_busy) gap_min_busy = $realtime - t_rise;
                if ($realtime - t_rise > gap_max_busy) gap_max_busy = $realtime - t_rise;
            end
        end
        if (spi_sclk) bad++;
        bitc = 0; nbytes = 0; op = 8'hFF; cur_busy = 0;
    end

    always @(posedge spi_sclk) if (!spi_cs_n) begin
        sh = {sh[6:0], spi_mosi};
        bitc++;
        if (bitc % 8 == 0) begin
            if (nbytes == 0) begin
                op = sh;
                if (sh == 8'h05) begin
                    cur_busy = stuck || (busy_left > 0);
                    if (busy_left > 0) busy_left--;
                    stat = cur_busy ? 8'hFF : 8'hFE;
                end
            end else if (op == 8'h02 && nbytes <= 3) begin
                fa = {fa[15:0], sh};
            end else if (op == 8'h02) begin
                mem[int'(fa) + nbytes - 4] = sh;
            end
            nbytes++;
        end
    end

    always @(negedge spi_sclk) if (!spi_cs_n && op == 8'h05 && bitc >= 8 && bitc < 16)
        spi_miso = stat[15 - bitc];

    always @(posedge spi_cs_n) if (rst_n) begin
        t_rise = $realtime;
        if (spi_sclk) bad++;
        last_busy_poll = 0;
        if (op == 8'h05) begin
            if (nbytes != 2) bad++;
            polls++;
            if (cur_busy) begin busy_polls++; last_busy_poll = 1; seq = 0; end
            else seq = 1;
        end else if (op == 8'h06) begin
            if (nbytes != 1) bad++;
            wrens++;
            seq = (seq == 1) ? 2 : 0;
        end else if (op == 8'h02) begin
            if (seq != 2) bad++;
            seq = 0;
            if (nprog < 16) begin
                prog_addr[nprog] = int'(fa);
                prog_len[nprog]  = nbytes - 4;
            end
            nprog++;
            busy_left = busy_after;
        end else begin
            bad++;
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [7:0] pat(input int k, input int seed);
        return 8'((k * 13 + seed) & 8'hFF);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_write(input logic [23:0] a, input int n, input int pg,
                             input int stall, output bit got_done,
                             output bit got_err, output int fed);
        int  cyc;
        bit  acc;
        got_done = 0; got_err = 0; fed = 0; acc = 0; cyc = 0;
        @(negedge clk);
        start_addr = a; xfer_len = 16'(n); poll_gap = 16'(pg); start = 1'b1;
        while (!(got_done || got_err) && cyc < 60000) begin
            @(negedge clk);
            cyc++;
            start = 1'b0;
            if (acc) fed++;
            if (done)  got_done = 1;
            if (error) got_err = 1;
            wr_valid = (fed < n) && ((stall == 0) || (cyc % 5 >= stall));
            wr_data  = pat(fed, int'(a[7:0]));
            acc      = wr_valid && wr_ready;
        end
        wr_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_data(input logic [23:0] a, input int n, input string req);
        int miss = 0;
        for (int k = 0; k < n; k++) begin
            if (!mem.exists(int'(a) + k) || mem[int'(a) + k] !== pat(k, int'(a[7:0])))
                miss++;
        end
        check(miss == 0, req, "data bytes mismatched", miss, 0);
        check(mem.num() == n, req, "bytes written", mem.num(), n);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check(spi_cs_n === 1'b1, "R11", "cs_n after reset", int'(spi_cs_n), 1);
        check(spi_sclk === 1'b0, "R11", "sclk after reset", int'(spi_sclk), 0);
        check({busy, done, error, wr_ready} === 4'b0, "R11", "status after reset",
              int'({busy, done, error, wr_ready}), 0);
    endtask

    task automatic t_zero_len();
        bit d, e; int f;
        model_clear(); busy_after = 0; stuck = 0;
        run_write(24'h000040, 0, 0, 0, d, e, f);
        check(d && !e, "R8", "zero length done", int'(d), 1);
        check(polls + wrens + nprog == 0, "R8", "frames for zero length",
              polls + wrens + nprog, 0);
    endtask

    task automatic t_short();
        bit d, e; int f;
        model_clear(); busy_after = 0; stuck = 0;
        run_write(24'h123456, 5, 0, 0, d, e, f);
        check(d && nprog == 1, "R1", "single burst count", nprog, 1);
        check(prog_addr[0] == 32'h123456, "R1", "burst address", prog_addr[0], 32'h123456);
        check(prog_len[0] == 5, "R2", "short burst length", prog_len[0], 5);
        check_data(24'h123456, 5, "R1");
        check(polls == 1 && wrens == 1, "R4", "poll+wren count", polls * 10 + wrens, 11);
    endtask

    task automatic t_aligned();
        bit d, e; int f;
        model_clear(); busy_after = 0; stuck = 0;
        run_write(24'h000100, 256, 0, 0, d, e, f);
        check(d && nprog == 1, "R2", "full page in one burst", nprog, 1);
        check(prog_len[0] == 256, "R2", "full page length", prog_len[0], 256);
        check_data(24'h000100, 256, "R6");
        check(gap_min_all >= GAP_CYC * 5.0, "R7", "min cs gap ns",
              int'(gap_min_all), GAP_CYC * 5);
    endtask

    task automatic t_unaligned_busy();
        bit d, e; int f;
        model_clear(); busy_after = 2; stuck = 0;
        run_write(24'h0000F0, 300, 20, 0, d, e, f);
        check(d && !e, "R6", "unaligned run done", int'(d), 1);
        check(nprog == 3, "R2", "burst count", nprog, 3);
        check(prog_addr[0] == 32'hF0 && prog_len[0] == 16, "R2", "burst0 len",
              prog_len[0], 16);
        check(prog_addr[1] == 32'h100 && prog_len[1] == 256, "R6", "burst1 addr",
              prog_addr[1], 32'h100);
        check(prog_addr[2] == 32'h200 && prog_len[2] == 28, "R6", "burst2 len",
              prog_len[2], 28);
        check_data(24'h0000F0, 300, "R6");
        check(polls == 7, "R3", "status polls", polls, 7);
        check(busy_polls == 4, "R3", "busy polls", busy_polls, 4);
        check(wrens == 3, "R4", "write enables", wrens, 3);
        check(gap_min_busy >= (GAP_CYC + 20) * 5.0 && gap_max_busy <= (GAP_CYC + 22) * 5.0,
              "R5", "busy poll gap ns", int'(gap_min_busy), (GAP_CYC + 20) * 5);
        check(bad == 0, "R4", "frame order/format violations", bad, 0);
    endtask

    task automatic t_zero_gap_stall();
        bit d, e; int f;
        model_clear(); busy_after = 1; stuck = 0;
        run_write(24'h0001FE, 4, 0, 3, d, e, f);
        check(d && nprog == 2, "R2", "page-cross short bursts", nprog, 2);
        check(prog_len[0] == 2 && prog_len[1] == 2, "R2", "split lengths",
              prog_len[0] * 10 + prog_len[1], 22);
        check(f == 4, "R10", "stream bytes consumed", f, 4);
        check_data(24'h0001FE, 4, "R10");
        check(gap_min_busy >= GAP_CYC * 5.0 && gap_max_busy <= (GAP_CYC + 2) * 5.0,
              "R5", "zero-delay poll gap ns", int'(gap_min_busy), GAP_CYC * 5);
        check(bad == 0, "R7", "mode-0/frame violations", bad, 0);
    endtask

    task automatic t_stuck();
        bit d, e; int f;
        model_clear(); busy_after = 0; stuck = 1;
        run_write(24'h000300, 10, 0, 0, d, e, f);
        stuck = 0;
        check(e && !d, "R9", "error on poll limit", int'(e), 1);
        check(busy_polls == POLL_LIMIT, "R9", "busy polls before error",
              busy_polls, POLL_LIMIT);
        check(nprog == 0 && wrens == 0, "R9", "program frames after stuck",
              nprog + wrens, 0);
        check(spi_cs_n === 1'b1 && busy === 1'b0, "R9", "cs high and idle",
              int'({spi_cs_n, busy}), 2);
        check(f == 0, "R10", "no stream bytes taken", f, 0);
    endtask

    initial begin
        t_rise = 0.0;
        model_clear(); busy_after = 0; stuck = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_zero_len();
        t_short();
        t_aligned();
        t_unaligned_busy();
        t_zero_gap_stall();
        t_stuck();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                checks++; errors++;
                $display("FAIL watchdog: actual %0d cycles expected under 190000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end
endmodule